// File: doc/BRIEF.md
# Connection Memory Block Programming Engine

This block is a hardware sequencer that initialises the connection memory of a time slot switch without a stream of processor writes. Once started, it writes a 3-bit channel mode value into the high half of every selected connection entry, one entry per clock. When asked, it also zeroes the source-address bits held in the low half of each entry. It can cover the whole memory or a rectangle of streams and channels inside one stream group. A start register and an end register bound that rectangle.

Software writes the start and end registers, then writes the control register with the enable bit set. The enable bit reads back as 1 while the engine runs and drops to 0 on its own when the last entry is written. At that point the mode field is also cleared. Writing the enable bit to 0 during a run stops the engine at once. While a run is in progress, processor writes to the connection memory are held off through a stall output. The connection memory sits outside the block and is reached through a plain RAM write port.

Top module: `cm_blkprog_top`

## Requirements
- R1: The engine starts only on a control write that sets the enable bit (bit 0) while the enable bit is 0. From the following cycle it writes exactly one entry per clock, with `busy` high, until it finishes. A control write with bit 0 clear while idle does not start a run.
- R2: Every entry the engine writes receives the control register mode field (bits 6:4) on the high-half port (`cm_hi_wdata`).
- R3: When the clear-low bit (control bit 2) is 1, each entry written also gets a low-half write of all zeros. When it is 0, no low-half write happens during the run.
- R4: When the full bit (control bit 1) is 1, the start and end registers are ignored and all 2^(GRP_W+STR_W+CH_W) entries are written, channel 0 first.
- R5: When the full bit is 0, the group comes from the start register. A global stream is group*2^STR_W + the stream field. The walk covers the channel field from start to end and, for each channel, every stream from start to end before it moves on. Register fields: channel [CH_W-1:0], stream [CH_W+STR_W-1:CH_W], group [RW-1:CH_W+STR_W] (group bits of the end register are unused). The memory address is {global stream, channel}.
- R6: If a start field is above its end field, that field counts up through its top value and wraps to 0. The stream field and the channel field wrap independently.
- R7: After the last entry is written, `busy` and the enable bit fall and the mode field reads 0. The full and clear-low bits keep their values.
- R8: A control write with bit 0 clear during a run aborts it at that clock edge, so later entries keep their previous contents.
- R9: While idle, processor writes pass straight to the memory port (`cpu_hi` picks the half). While busy, `cpu_stall` is high and processor writes do not reach the memory.
- R10: After reset the control register reads 0, the start register reads 0 and the end register reads all ones.
- R11: During a run, writes to the start and end registers and to the control fields other than the enable bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 start, 2 end |
| reg_wdata | input | DW | Register write data |
| ctl_q | output | 7 | Control register read-back |
| start_q | output | RW | Start register read-back |
| end_q | output | RW | End register read-back |
| busy | output | 1 | Engine running |
| cpu_we | input | 1 | Processor connection memory write |
| cpu_hi | input | 1 | 1 selects high half, 0 low half |
| cpu_addr | input | AW | Processor write address |
| cpu_wdata | input | AW | Processor write data (high half uses bits 2:0) |
| cpu_stall | output | 1 | Processor write held off |
| cm_addr | output | AW | Memory write address |
| cm_hi_we | output | 1 | High-half write enable |
| cm_hi_wdata | output | 3 | High-half mode data |
| cm_lo_we | output | 1 | Low-half write enable |
| cm_lo_wdata | output | AW | Low-half data |

## Verification
On every cycle, the assertions check the following: the channel counter holds or steps by one, the group bits stay fixed in group mode, the engine's high writes carry the mode field, low writes happen only with clear-low set and carry zeros, a run starts only from a control write, and the registers hold during a run. Some behaviour can only be shown by the bench scenarios against a memory model. These are the exact channel-major address order, the independent wrap of the two fields, full coverage that ignores the range, the entry count and cycle count of a run, the point at which an abort leaves entries untouched, and the effect of a stalled processor write.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CTL_W    = 7;
  localparam int EN_B     = 0;
  localparam int FULL_B   = 1;
  localparam int CLR_B    = 2;
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;

  typedef enum logic [1:0] {
    SEL_CTL   = 2'd0,
    SEL_START = 2'd1,
    SEL_END   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bp_regs.sv
module bp_regs
  import bp_pkg::*;
#(
  parameter int RW = 15,
  parameter int DW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              done,
  output logic              en_q,
  output logic              full_q,
  output logic              clr_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [RW-1:0]     start_q,
  output logic [RW-1:0]     end_q,
  output logic              start_go,
  output logic              full_ld
);
  logic              en_d, full_d, clr_d;
  logic [MODE_W-1:0] mode_d;
  logic [RW-1:0]     start_d, end_d;
  logic              wr_ctl, wr_start, wr_end;

  assign wr_ctl   = reg_wr && (reg_sel == SEL_CTL);
  assign wr_start = reg_wr && (reg_sel == SEL_START);
  assign wr_end   = reg_wr && (reg_sel == SEL_END);
  assign start_go = wr_ctl && reg_wdata[EN_B] && !en_q;
  assign full_ld  = reg_wdata[FULL_B];

  always_comb begin
    en_d    = en_q;
    full_d  = full_q;
    clr_d   = clr_q;
    mode_d  = mode_q;
    start_d = start_q;
    end_d   = end_q;
    if (en_q) begin
      if (wr_ctl && !reg_wdata[EN_B]) en_d = 1'b0;
      if (done) begin
        en_d   = 1'b0;
        mode_d = '0;
      end
    end else begin
      if (wr_ctl) begin
        en_d   = reg_wdata[EN_B];
        full_d = reg_wdata[FULL_B];
        clr_d  = reg_wdata[CLR_B];
        mode_d = reg_wdata[MODE_LSB +: MODE_W];
      end
      if (wr_start) start_d = reg_wdata[RW-1:0];
      if (wr_end)   end_d   = reg_wdata[RW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      full_q  <= 1'b0;
      clr_q   <= 1'b0;
      mode_q  <= '0;
      start_q <= '0;
      end_q   <= '1;
    end else begin
      en_q    <= en_d;
      full_q  <= full_d;
      clr_q   <= clr_d;
      mode_q  <= mode_d;
      start_q <= start_d;
      end_q   <= end_d;
    end
  end

  assert_start_by_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(reg_wr && (reg_sel == SEL_CTL)));

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && done) |=> (!en_q && (mode_q == '0)));

  assert_regs_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> ($stable(start_q) && $stable(end_q) &&
                              $stable(full_q) && $stable(clr_q)));
endmodule

// File: rtl/bp_walker.sv
module bp_walker #(
  parameter int GRP_W = 3,
  parameter int STR_W = 3,
  parameter int CH_W  = 9,
  localparam int SW   = GRP_W + STR_W,
  localparam int RW   = GRP_W + STR_W + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              full_ld,
  input  logic              run,
  input  logic              full,
  input  logic [RW-1:0]     start_q,
  input  logic [STR_W+CH_W-1:0] end_q,
  output logic [SW-1:0]     stream_q,
  output logic [CH_W-1:0]   chan_q,
  output logic              last
);
  logic [CH_W-1:0]  st_ch, en_ch;
  logic [STR_W-1:0] st_str, en_str;
  logic [GRP_W-1:0] st_grp;
  logic [SW-1:0]    s_first_ld, s_first, s_last, s_step, stream_d;
  logic [CH_W-1:0]  c_first_ld, c_last, chan_d;
  logic             s_wrap, cnt_en;

  assign st_ch  = start_q[CH_W-1:0];
  assign st_str = start_q[CH_W +: STR_W];
  assign st_grp = start_q[CH_W+STR_W +: GRP_W];
  assign en_ch  = end_q[CH_W-1:0];
  assign en_str = end_q[CH_W +: STR_W];

  assign s_first_ld = full_ld ? '0 : {st_grp, st_str};
  assign c_first_ld = full_ld ? '0 : st_ch;
  assign s_first    = full ? '0 : {st_grp, st_str};
  assign s_last     = full ? {SW{1'b1}} : {st_grp, en_str};
  assign c_last     = full ? {CH_W{1'b1}} : en_ch;
  assign s_step     = full ? (stream_q + 1'b1)
                           : {stream_q[SW-1:STR_W], stream_q[STR_W-1:0] + 1'b1};

  assign s_wrap = (stream_q == s_last);
  assign last   = s_wrap && (chan_q == c_last);
  assign cnt_en = load || run;

  always_comb begin
    stream_d = stream_q;
    chan_d   = chan_q;
    if (load) begin
      stream_d = s_first_ld;
      chan_d   = c_first_ld;
    end else if (run) begin
      if (s_wrap) begin
        stream_d = s_first;
        chan_d   = chan_q + 1'b1;
      end else begin
        stream_d = s_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream_q <= '0;
      chan_q   <= '0;
    end else if (cnt_en) begin
      stream_q <= stream_d;
      chan_q   <= chan_d;
    end
  end

  assert_chan_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(load)) |->
      ((chan_q == $past(chan_q)) || (chan_q == $past(chan_q) + 1'b1)));

  assert_group_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !full && !load) |-> (stream_q[SW-1:STR_W] == st_grp));
endmodule

// File: rtl/bp_cm_port.sv
module bp_cm_port #(
  parameter int AW     = 15,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              clr,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     eng_addr,
  input  logic              cpu_we,
  input  logic              cpu_hi,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [AW-1:0]     cpu_wdata,
  output logic              cpu_stall,
  output logic [AW-1:0]     cm_addr,
  output logic              cm_hi_we,
  output logic [MODE_W-1:0] cm_hi_wdata,
  output logic              cm_lo_we,
  output logic [AW-1:0]     cm_lo_wdata
);
  always_comb begin
    if (busy) begin
      cm_addr     = eng_addr;
      cm_hi_we    = 1'b1;
      cm_hi_wdata = mode;
      cm_lo_we    = clr;
      cm_lo_wdata = '0;
    end else begin
      cm_addr     = cpu_addr;
      cm_hi_we    = cpu_we && cpu_hi;
      cm_hi_wdata = cpu_wdata[MODE_W-1:0];
      cm_lo_we    = cpu_we && !cpu_hi;
      cm_lo_wdata = cpu_wdata;
    end
  end

  assign cpu_stall = busy;

  assert_mode_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cm_hi_we && (cm_hi_wdata == mode)));

  assert_no_low_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |-> !cm_lo_we);

  assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cm_lo_we) |-> (cm_lo_wdata == '0));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we) |-> cpu_stall);
endmodule

// File: rtl/cm_blkprog_top.sv
module cm_blkprog_top
  import bp_pkg::*;
#(
  parameter int GRP_W = 3,
  parameter int STR_W = 3,
  parameter int CH_W  = 9,
  localparam int AW   = GRP_W + STR_W + CH_W,
  localparam int RW   = AW,
  localparam int DW   = (RW > CTL_W) ? RW : CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [RW-1:0]     start_q,
  output logic [RW-1:0]     end_q,
  output logic              busy,
  input  logic              cpu_we,
  input  logic              cpu_hi,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [AW-1:0]     cpu_wdata,
  output logic              cpu_stall,
  output logic [AW-1:0]     cm_addr,
  output logic              cm_hi_we,
  output logic [MODE_W-1:0] cm_hi_wdata,
  output logic              cm_lo_we,
  output logic [AW-1:0]     cm_lo_wdata
);
  localparam int SW = GRP_W + STR_W;

  logic              en_q, full_q, clr_q, start_go, full_ld, last;
  logic [MODE_W-1:0] mode_q;
  logic [SW-1:0]     stream_q;
  logic [CH_W-1:0]   chan_q;

  bp_regs #(.RW(RW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .done(last), .en_q(en_q), .full_q(full_q),
    .clr_q(clr_q), .mode_q(mode_q), .start_q(start_q), .end_q(end_q),
    .start_go(start_go), .full_ld(full_ld)
  );

  bp_walker #(.GRP_W(GRP_W), .STR_W(STR_W), .CH_W(CH_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .load(start_go), .full_ld(full_ld),
    .run(en_q), .full(full_q), .start_q(start_q),
    .end_q(end_q[STR_W+CH_W-1:0]), .stream_q(stream_q), .chan_q(chan_q),
    .last(last)
  );

  bp_cm_port #(.AW(AW), .MODE_W(MODE_W)) port_i (
    .clk(clk), .rst_n(rst_n), .busy(en_q), .clr(clr_q), .mode(mode_q),
    .eng_addr({stream_q, chan_q}), .cpu_we(cpu_we), .cpu_hi(cpu_hi),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
    .cm_addr(cm_addr), .cm_hi_we(cm_hi_we), .cm_hi_wdata(cm_hi_wdata),
    .cm_lo_we(cm_lo_we), .cm_lo_wdata(cm_lo_wdata)
  );

  assign busy  = en_q;
  assign ctl_q = {mode_q, 1'b0, clr_q, full_q, en_q};
endmodule

// File: tb/cm_blkprog_top_tb_top.sv
`timescale 1ns/1ps
module cm_blkprog_top_tb_top;
  localparam int GRP_W = 2;
  localparam int STR_W = 2;
  localparam int CH_W  = 3;
  localparam int AW    = GRP_W + STR_W + CH_W;
  localparam int N     = 1 << AW;

  logic clk, rst_n;
  logic reg_wr;
  logic [1:0] reg_sel;
  logic [AW-1:0] reg_wdata;
  logic [6:0] ctl_q;
  logic [AW-1:0] start_q, end_q;
  logic busy, cpu_we, cpu_hi, cpu_stall;
  logic [AW-1:0] cpu_addr, cpu_wdata, cm_addr, cm_lo_wdata;
  logic cm_hi_we, cm_lo_we;
  logic [2:0] cm_hi_wdata;

  int checks = 0;
  int errors = 0;

  cm_blkprog_top #(.GRP_W(GRP_W), .STR_W(STR_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctl_q(ctl_q), .start_q(start_q), .end_q(end_q),
    .busy(busy), .cpu_we(cpu_we), .cpu_hi(cpu_hi), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cm_addr(cm_addr),
    .cm_hi_we(cm_hi_we), .cm_hi_wdata(cm_hi_wdata), .cm_lo_we(cm_lo_we),
    .cm_lo_wdata(cm_lo_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model plus log of engine write addresses
  logic [2:0]    mhi  [0:N-1];
  logic [AW-1:0] mlo  [0:N-1];
  logic [AW-1:0] wlog [0:1023];
  int nlog = 0;
  int nlo  = 0;

  always @(posedge clk) begin
    if (cm_hi_we) begin
      mhi[cm_addr] <= cm_hi_wdata;
      if (busy) begin
        wlog[nlog] <= cm_addr;
        nlog <= nlog + 1;
      end
    end
    if (cm_lo_we) begin
      mlo[cm_addr] <= cm_lo_wdata;
      nlo <= nlo + 1;
    end
  end

  function automatic logic [AW-1:0] ctlw(bit en, bit full, bit clr, logic [2:0] mode);
    return AW'({mode, 1'b0, clr, full, en});
  endfunction

  function automatic logic [AW-1:0] rng(int grp, int str, int ch);
    return AW'((grp << (STR_W + CH_W)) | (str << CH_W) | ch);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [AW-1:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic preload();
    for (int a = 0; a < N; a++) begin
      cpu_we = 1'b1; cpu_hi = 1'b1; cpu_addr = AW'(a); cpu_wdata = AW'(2);
      @(negedge clk);
      cpu_hi = 1'b0; cpu_wdata = AW'(a + 1);
      @(negedge clk);
    end
    cpu_we = 1'b0;
  endtask

  task automatic run_count(output int cyc);
    cyc = 0;
    while (busy && cyc < 4000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(ctl_q == 7'h00, "R10 ctl reset", ctl_q, 0);
    chk(start_q == '0, "R10 start reset", start_q, 0);
    chk(end_q == {AW{1'b1}}, "R10 end reset", end_q, N - 1);
    chk(!busy && !cpu_stall, "R10 idle", busy, 0);
  endtask

  task automatic t_cpu_idle();
    preload();
    chk(mhi[5] == 3'd2 && mlo[5] == AW'(6), "R9 idle passthrough", mlo[5], 6);
  endtask

  task automatic t_no_start();
    int n0 = nlog;
    wr_reg(2'd0, ctlw(0, 1, 1, 3'd5));
    @(negedge clk);
    chk(!busy && nlog == n0, "R1 no start without enable", nlog - n0, 0);
    chk(ctl_q == 7'h56, "R1 idle ctl write", ctl_q, 'h56);
  endtask

  task automatic t_full();
    int n0, l0, cyc, bad;
    preload();
    wr_reg(2'd1, rng(1, 2, 3));
    wr_reg(2'd2, rng(0, 2, 4));
    n0 = nlog; l0 = nlo;
    wr_reg(2'd0, ctlw(1, 1, 1, 3'd5));
    chk(busy, "R1 busy after start", busy, 1);
    run_count(cyc);
    chk(cyc == N, "R1 one write per cycle", cyc, N);
    chk(nlog - n0 == N, "R4 full count", nlog - n0, N);
    chk(nlo - l0 == N, "R3 full low writes", nlo - l0, N);
    bad = 0;
    for (int k = 0; k < N; k++) begin
      int s = k % (1 << (GRP_W + STR_W));
      int c = k / (1 << (GRP_W + STR_W));
      if (wlog[n0 + k] != AW'((s << CH_W) | c)) bad++;
    end
    chk(bad == 0, "R4 full channel-major order", bad, 0);
    bad = 0;
    for (int a = 0; a < N; a++) if (mhi[a] != 3'd5 || mlo[a] != '0) bad++;
    chk(bad == 0, "R2 R3 full contents", bad, 0);
    chk(ctl_q == 7'h06, "R7 completion clears", ctl_q, 'h06);
  endtask

  task automatic t_group();
    int n0, l0, cyc, bad, k;
    preload();
    wr_reg(2'd1, rng(2, 1, 2));
    wr_reg(2'd2, rng(0, 2, 4));
    n0 = nlog; l0 = nlo;
    wr_reg(2'd0, ctlw(1, 0, 0, 3'd3));
    run_count(cyc);
    chk(nlog - n0 == 6 && cyc == 6, "R5 group count", nlog - n0, 6);
    bad = 0; k = 0;
    for (int c = 2; c <= 4; c++)
      for (int s = 1; s <= 2; s++) begin
        if (wlog[n0 + k] != AW'(((8 + s) << CH_W) | c)) bad++;
        k++;
      end
    chk(bad == 0, "R5 group order", bad, 0);
    chk(mhi[(9 << CH_W) | 3] == 3'd3 && mhi[(9 << CH_W) | 5] == 3'd2,
        "R2 group contents", mhi[(9 << CH_W) | 3], 3);
    chk(nlo == l0 && mlo[(9 << CH_W) | 3] == AW'(((9 << CH_W) | 3) + 1),
        "R3 low kept when clear off", nlo - l0, 0);
    chk(ctl_q == 7'h00, "R7 group completion", ctl_q, 0);
  endtask

  task automatic t_wrap();
    int n0, cyc, bad, k;
    int chs[4] = '{6, 7, 0, 1};
    int sts[2] = '{3, 0};
    wr_reg(2'd1, rng(1, 3, 6));
    wr_reg(2'd2, rng(0, 0, 1));
    n0 = nlog;
    wr_reg(2'd0, ctlw(1, 0, 0, 3'd6));
    run_count(cyc);
    chk(nlog - n0 == 8, "R6 wrap count", nlog - n0, 8);
    bad = 0; k = 0;
    foreach (chs[i])
      foreach (sts[j]) begin
        if (wlog[n0 + k] != AW'(((4 + sts[j]) << CH_W) | chs[i])) bad++;
        k++;
      end
    chk(bad == 0, "R6 independent wrap order", bad, 0);
  endtask

  task automatic t_abort();
    int n0;
    preload();
    n0 = nlog;
    wr_reg(2'd0, ctlw(1, 1, 0, 3'd7));
    repeat (10) @(negedge clk);
    wr_reg(2'd0, ctlw(0, 1, 0, 3'd7));
    chk(!busy, "R8 abort stops", busy, 0);
    chk(nlog - n0 == 11, "R8 abort write count", nlog - n0, 11);
    chk(mhi[N - 1] == 3'd2, "R8 later entry untouched", mhi[N - 1], 2);
    chk(ctl_q == 7'h72, "R8 ctl after abort", ctl_q, 'h72);
  endtask

  task automatic t_stall_hold();
    int cyc;
    preload();
    wr_reg(2'd1, rng(0, 0, 0));
    wr_reg(2'd2, rng(0, 3, 7));
    wr_reg(2'd0, ctlw(1, 0, 0, 3'd1));
    cpu_we = 1'b1; cpu_hi = 1'b1; cpu_addr = AW'(N - 1); cpu_wdata = AW'(6);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = rng(1, 1, 1);
    @(negedge clk);
    chk(cpu_stall, "R9 stall while busy", cpu_stall, 1);
    reg_sel = 2'd0; reg_wdata = ctlw(1, 1, 1, 3'd4);
    @(negedge clk);
    reg_wr = 1'b0; cpu_we = 1'b0;
    run_count(cyc);
    chk(cyc == 30, "R11 run unaffected by writes", cyc, 30);
    chk(mhi[N - 1] == 3'd2, "R9 stalled write dropped", mhi[N - 1], 2);
    chk(start_q == '0, "R11 start held", start_q, 0);
    chk(ctl_q == 7'h00, "R11 ctl fields held", ctl_q, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    cpu_we = 1'b0; cpu_hi = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cpu_idle();
    t_no_start();
    t_full();
    t_group();
    t_wrap();
    t_abort();
    t_stall_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule